// File: doc/BRIEF.md
# ADC Standard and Injected Conversion Sequencer

This block decides what an analog-to-digital converter converts next. It handles two kinds of request. Standard conversions are started by software and run in one of four scan modes. Injected conversions are requested by a hardware event such as a capture/compare match, and each converts one channel. The sequencer launches one conversion at a time through a start/done handshake with the converter. It stores the results in two separate result registers and raises a sticky end-of-conversion flag for each kind.

When both kinds of request are waiting, an injected request always wins. A standard start that arrives while an injected conversion is in flight never aborts it. The standard start is held back and launches on the cycle after the injected conversion finishes. This holds even when the start arrives in the last cycles before that finish, or on the very cycle the converter reports done.

The request-pending bit seen by software is only a status copy. Injection processing is driven by a separate latch that software cannot write. The reset input is asynchronous and active low, and is expected to be released synchronously to the clock.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `std_run`, `inj_pend`, `std_eoc`, `inj_eoc`, `cnv_start`, `std_data` and `inj_data` are all zero.
- R2: With `cfg_mode` = 0 (single), a `cfg_start` pulse launches exactly one standard conversion of `cfg_chan`. On completion, `std_data` holds the converter data, `std_data_chan` holds the channel, `std_eoc` is set and `std_run` drops.
- R3: `std_run` rises only after a `cfg_start` pulse. With `cfg_mode` = 1 (repeat one channel), the same channel is converted again and again until `cfg_stop`. After `cfg_stop`, a conversion already launched completes and no new one starts.
- R4: With `cfg_mode` = 2 (scan), channels are converted from `cfg_chan` down to 0, one each, and then `std_run` drops.
- R5: With `cfg_mode` = 3 (repeat scan), the channel order wraps from 0 back to `cfg_chan` until `cfg_stop`.
- R6: An injected conversion of `inj_chan` writes its data to `inj_data` and sets `inj_eoc`. It leaves `std_data` unchanged and is marked by `cnv_inj` = 1 at its launch.
- R7: An accepted `inj_req` sets `inj_pend` on the next edge. `inj_pend` stays set until the edge that samples the injected conversion's `cnv_done`, and it is clear after that edge.
- R8: A `cfg_start` during an injected conversion does not abort it. The standard conversion launches on the cycle right after the injected `cnv_done`.
- R9: A `cfg_start` at any cycle from the injection request up to and past the injected `cnv_done` (including that cycle) loses neither the injected result nor its flag. It still starts the standard conversion, and later injection requests are still served.
- R10: An `inj_req` during a standard conversion launches on the cycle after that conversion completes, before the next standard conversion of the sequence.
- R11: A write through `pend_wr` changes only the visible `inj_pend`. Clearing it does not stop a pending injection, and setting it launches nothing.
- R12: At most one conversion is outstanding: `cnv_start` is never asserted between a launch and its `cnv_done`.
- R13: `std_eoc` and `inj_eoc` stay set until cleared by `std_eoc_clr` / `inj_eoc_clr`. A clear on the same cycle as a completion leaves the flag set.
- R14: An `inj_req` while an injection is pending or running is ignored (its channel is not used) unless it coincides with that injection's `cnv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Software start pulse for standard conversions |
| cfg_stop | input | 1 | Software stop pulse (clears the run bit) |
| cfg_mode | input | 2 | 0 single, 1 repeat channel, 2 scan down, 3 repeat scan |
| cfg_chan | input | CH_W | Standard channel, or scan start channel |
| inj_req | input | 1 | Hardware injection request pulse |
| inj_chan | input | CH_W | Channel for the injected conversion |
| pend_wr | input | 1 | Software write strobe for the visible pending bit |
| pend_wdata | input | 1 | Value written to the visible pending bit |
| cnv_done | input | 1 | Converter finished the outstanding conversion |
| cnv_data | input | DATA_W | Converter result, valid with cnv_done |
| std_eoc_clr | input | 1 | Clear standard end-of-conversion flag |
| inj_eoc_clr | input | 1 | Clear injected end-of-conversion flag |
| cnv_start | output | 1 | Launch strobe to the converter |
| cnv_inj | output | 1 | Launched conversion is an injected one |
| cnv_chan | output | CH_W | Channel of the launched conversion |
| std_run | output | 1 | Standard run bit |
| inj_pend | output | 1 | Visible injection pending bit |
| std_data | output | DATA_W | Standard result register |
| std_data_chan | output | CH_W | Channel of the standard result |
| inj_data | output | DATA_W | Injected result register |
| std_eoc | output | 1 | Standard end-of-conversion flag |
| inj_eoc | output | 1 | Injected end-of-conversion flag |

## Verification
Each scan mode is swept over every start channel, so the launch log tells apart a down-count, a wrap back to the start channel, and a stop after the in-flight conversion. A second sweep places the software start at each cycle offset from the injection request through past its completion. This separates a start before the launch, during the run, in the two cycles before the end, on the done cycle itself, and after it. In every case both results, both flags and a follow-up injection must appear. Further patterns show the results of each kind landing only in their own register (including an injection arriving mid-scan), requests repeated while one is pending, software writes to the pending bit during and without an injection, and a flag clear on the cycle of its own completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // standard conversion modes; bit 0 = repeat, bit 1 = scan
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_RSCAN  = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_STD  = 2'd1,
    ARB_INJ  = 2'd2
  } arb_state_e;

endpackage

// File: rtl/adc_seq_std.sv
module adc_seq_std
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [1:0]      mode_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            std_done_i,
  output logic            run_o,
  output logic [CH_W-1:0] chan_o
);

  logic            run_q, run_n;
  scan_mode_e      mode_q, mode_n;
  logic [CH_W-1:0] base_q, base_n;
  logic [CH_W-1:0] chan_q, chan_n;
  logic            is_scan, is_repeat, at_floor;

  assign is_scan   = (mode_q == MODE_SCAN) || (mode_q == MODE_RSCAN);
  assign is_repeat = (mode_q == MODE_REPEAT) || (mode_q == MODE_RSCAN);
  assign at_floor  = (chan_q == '0);

  always_comb begin
    run_n  = run_q;
    mode_n = mode_q;
    base_n = base_q;
    chan_n = chan_q;
    if (std_done_i) begin
      if (is_scan) begin
        if (at_floor) begin
          if (is_repeat) chan_n = base_q;
          else           run_n  = 1'b0;
        end else begin
          chan_n = chan_q - 1'b1;
        end
      end else if (!is_repeat) begin
        run_n = 1'b0;
      end
    end
    if (stop_i) run_n = 1'b0;
    // a new start restarts the sequence from the programmed channel
    if (start_i) begin
      run_n  = 1'b1;
      mode_n = scan_mode_e'(mode_i);
      base_n = chan_i;
      chan_n = chan_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_SINGLE;
      base_q <= '0;
      chan_q <= '0;
    end else begin
      run_q  <= run_n;
      mode_q <= mode_n;
      base_q <= base_n;
      chan_q <= chan_n;
    end
  end

  assign run_o  = run_q;
  assign chan_o = chan_q;

endmodule

// File: rtl/adc_seq_inj.sv
module adc_seq_inj #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            pend_wr_i,
  input  logic            pend_val_i,
  input  logic            inj_done_i,
  output logic            want_o,
  output logic [CH_W-1:0] chan_o,
  output logic            pend_o
);

  // hidden latch drives processing; pend_q is only the visible copy
  logic            act_q, act_n;
  logic            pend_q, pend_n;
  logic [CH_W-1:0] chan_q, chan_n;
  logic            accept;

  assign accept = req_i && (!act_q || inj_done_i);

  always_comb begin
    act_n  = act_q;
    pend_n = pend_q;
    chan_n = chan_q;
    if (inj_done_i) act_n = 1'b0;
    if (pend_wr_i)  pend_n = pend_val_i;
    if (inj_done_i) pend_n = 1'b0;
    if (accept) begin
      act_n  = 1'b1;
      pend_n = 1'b1;
      chan_n = chan_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      chan_q <= '0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      chan_q <= chan_n;
    end
  end

  assign want_o = act_q;
  assign chan_o = chan_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            std_want_i,
  input  logic [CH_W-1:0] std_chan_i,
  input  logic            inj_want_i,
  input  logic [CH_W-1:0] inj_chan_i,
  input  logic            cnv_done_i,
  output logic            cnv_start_o,
  output logic            cnv_inj_o,
  output logic [CH_W-1:0] cnv_chan_o,
  output logic            std_done_o,
  output logic            inj_done_o,
  output logic [CH_W-1:0] act_chan_o
);

  arb_state_e      state_q, state_n;
  logic [CH_W-1:0] act_chan_q, act_chan_n;
  logic            idle, go_inj, go_std;

  assign idle   = (state_q == ARB_IDLE);
  assign go_inj = idle && inj_want_i;
  assign go_std = idle && !inj_want_i && std_want_i;

  always_comb begin
    state_n    = state_q;
    act_chan_n = act_chan_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (go_inj) begin
          state_n    = ARB_INJ;
          act_chan_n = inj_chan_i;
        end else if (go_std) begin
          state_n    = ARB_STD;
          act_chan_n = std_chan_i;
        end
      end
      ARB_STD, ARB_INJ: begin
        if (cnv_done_i) state_n = ARB_IDLE;
      end
      default: state_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ARB_IDLE;
      act_chan_q <= '0;
    end else begin
      state_q    <= state_n;
      act_chan_q <= act_chan_n;
    end
  end

  assign cnv_start_o = go_inj || go_std;
  assign cnv_inj_o   = go_inj;
  assign cnv_chan_o  = go_inj ? inj_chan_i : std_chan_i;
  assign std_done_o  = (state_q == ARB_STD) && cnv_done_i;
  assign inj_done_o  = (state_q == ARB_INJ) && cnv_done_i;
  assign act_chan_o  = act_chan_q;

endmodule

// File: rtl/adc_seq_res.sv
module adc_seq_res #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_done_i,
  input  logic              inj_done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   act_chan_i,
  input  logic              std_clr_i,
  input  logic              inj_clr_i,
  output logic [DATA_W-1:0] std_data_o,
  output logic [CH_W-1:0]   std_chan_o,
  output logic [DATA_W-1:0] inj_data_o,
  output logic              std_eoc_o,
  output logic              inj_eoc_o
);

  logic [DATA_W-1:0] std_data_q, inj_data_q;
  logic [CH_W-1:0]   std_chan_q;
  logic              std_eoc_q, std_eoc_n;
  logic              inj_eoc_q, inj_eoc_n;

  // set beats clear
  assign std_eoc_n = std_done_i || (std_eoc_q && !std_clr_i);
  assign inj_eoc_n = inj_done_i || (inj_eoc_q && !inj_clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_data_q <= '0;
      std_chan_q <= '0;
    end else if (std_done_i) begin
      std_data_q <= data_i;
      std_chan_q <= act_chan_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inj_data_q <= '0;
    else if (inj_done_i) inj_data_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_eoc_q <= 1'b0;
      inj_eoc_q <= 1'b0;
    end else begin
      std_eoc_q <= std_eoc_n;
      inj_eoc_q <= inj_eoc_n;
    end
  end

  assign std_data_o = std_data_q;
  assign std_chan_o = std_chan_q;
  assign inj_data_o = inj_data_q;
  assign std_eoc_o  = std_eoc_q;
  assign inj_eoc_o  = inj_eoc_q;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_stop,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              inj_req,
  input  logic [CH_W-1:0]   inj_chan,
  input  logic              pend_wr,
  input  logic              pend_wdata,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic              std_eoc_clr,
  input  logic              inj_eoc_clr,
  output logic              cnv_start,
  output logic              cnv_inj,
  output logic [CH_W-1:0]   cnv_chan,
  output logic              std_run,
  output logic              inj_pend,
  output logic [DATA_W-1:0] std_data,
  output logic [CH_W-1:0]   std_data_chan,
  output logic [DATA_W-1:0] inj_data,
  output logic              std_eoc,
  output logic              inj_eoc
);

  logic [CH_W-1:0] std_next_chan;
  logic [CH_W-1:0] inj_held_chan;
  logic [CH_W-1:0] act_chan;
  logic            inj_want;
  logic            std_done;
  logic            inj_done;

  adc_seq_std #(.CH_W(CH_W)) u_std (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (cfg_start),
    .stop_i     (cfg_stop),
    .mode_i     (cfg_mode),
    .chan_i     (cfg_chan),
    .std_done_i (std_done),
    .run_o      (std_run),
    .chan_o     (std_next_chan)
  );

  adc_seq_inj #(.CH_W(CH_W)) u_inj (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (inj_req),
    .chan_i     (inj_chan),
    .pend_wr_i  (pend_wr),
    .pend_val_i (pend_wdata),
    .inj_done_i (inj_done),
    .want_o     (inj_want),
    .chan_o     (inj_held_chan),
    .pend_o     (inj_pend)
  );

  adc_seq_arb #(.CH_W(CH_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .std_want_i  (std_run),
    .std_chan_i  (std_next_chan),
    .inj_want_i  (inj_want),
    .inj_chan_i  (inj_held_chan),
    .cnv_done_i  (cnv_done),
    .cnv_start_o (cnv_start),
    .cnv_inj_o   (cnv_inj),
    .cnv_chan_o  (cnv_chan),
    .std_done_o  (std_done),
    .inj_done_o  (inj_done),
    .act_chan_o  (act_chan)
  );

  adc_seq_res #(.CH_W(CH_W), .DATA_W(DATA_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .std_done_i (std_done),
    .inj_done_i (inj_done),
    .data_i     (cnv_data),
    .act_chan_i (act_chan),
    .std_clr_i  (std_eoc_clr),
    .inj_clr_i  (inj_eoc_clr),
    .std_data_o (std_data),
    .std_chan_o (std_data_chan),
    .inj_data_o (inj_data),
    .std_eoc_o  (std_eoc),
    .inj_eoc_o  (inj_eoc)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic              cfg_stop,
  input logic              pend_wr,
  input logic              cnv_done,
  input logic [DATA_W-1:0] cnv_data,
  input logic              std_eoc_clr,
  input logic              cnv_start,
  input logic              cnv_inj,
  input logic              std_run,
  input logic              inj_pend,
  input logic [DATA_W-1:0] std_data,
  input logic [DATA_W-1:0] inj_data,
  input logic              std_eoc,
  input logic              inj_eoc
);

  // conversion tracking seen from the converter side
  logic out_q;
  logic out_inj_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= 1'b0;
      out_inj_q <= 1'b0;
    end else if (cnv_start) begin
      out_q     <= 1'b1;
      out_inj_q <= cnv_inj;
    end else if (cnv_done) begin
      out_q     <= 1'b0;
    end
  end

  p_single_flight_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> !out_q);

  p_done_in_flight_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_done |-> out_q);

  p_std_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && out_q && !out_inj_q) |=> (std_eoc && std_data == $past(cnv_data)));

  p_inj_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && out_q && out_inj_q) |=>
      (inj_eoc && inj_data == $past(cnv_data) && std_data == $past(std_data)));

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pend && out_q && out_inj_q && !cnv_done && !pend_wr) |=> inj_pend);

  p_run_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_run) |-> $past(cfg_start));

  p_defer_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && out_q && out_inj_q && std_run && !cfg_stop) |=> cnv_start);

  p_eoc_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (std_eoc && !std_eoc_clr) |=> std_eoc);

endmodule

bind adc_seq_top adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_start   (cfg_start),
  .cfg_stop    (cfg_stop),
  .pend_wr     (pend_wr),
  .cnv_done    (cnv_done),
  .cnv_data    (cnv_data),
  .std_eoc_clr (std_eoc_clr),
  .cnv_start   (cnv_start),
  .cnv_inj     (cnv_inj),
  .std_run     (std_run),
  .inj_pend    (inj_pend),
  .std_data    (std_data),
  .inj_data    (inj_data),
  .std_eoc     (std_eoc),
  .inj_eoc     (inj_eoc)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int CH_W   = 3;
  localparam int DATA_W = 10;
  localparam int LAT    = 4;
  localparam int LOGN   = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              cfg_start, cfg_stop;
  logic [1:0]        cfg_mode;
  logic [CH_W-1:0]   cfg_chan;
  logic              inj_req;
  logic [CH_W-1:0]   inj_chan;
  logic              pend_wr, pend_wdata;
  logic              cnv_done;
  logic [DATA_W-1:0] cnv_data;
  logic              std_eoc_clr, inj_eoc_clr;
  logic              cnv_start, cnv_inj;
  logic [CH_W-1:0]   cnv_chan;
  logic              std_run, inj_pend;
  logic [DATA_W-1:0] std_data, inj_data;
  logic [CH_W-1:0]   std_data_chan;
  logic              std_eoc, inj_eoc;

  adc_seq_top #(.CH_W(CH_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_mode(cfg_mode), .cfg_chan(cfg_chan), .inj_req(inj_req), .inj_chan(inj_chan),
    .pend_wr(pend_wr), .pend_wdata(pend_wdata), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .std_eoc_clr(std_eoc_clr), .inj_eoc_clr(inj_eoc_clr), .cnv_start(cnv_start),
    .cnv_inj(cnv_inj), .cnv_chan(cnv_chan), .std_run(std_run), .inj_pend(inj_pend),
    .std_data(std_data), .std_data_chan(std_data_chan), .inj_data(inj_data),
    .std_eoc(std_eoc), .inj_eoc(inj_eoc)
  );

  function automatic logic [DATA_W-1:0] fval(input int ch);
    return DATA_W'(ch * 73 + 11);
  endfunction

  // fixed-latency converter model and launch log
  int              lat_cnt = 0;
  logic [CH_W-1:0] lat_ch = '0;
  logic            lat_inj = 1'b0;
  int              cyc = 0;
  int              log_n = 0;
  int              log_ch [LOGN];
  bit              log_inj [LOGN];
  int              log_cyc [LOGN];
  int              inj_done_cyc = 0;
  int              overlap = 0;

  assign cnv_done = (lat_cnt == 1);
  assign cnv_data = fval(int'(lat_ch));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (cnv_start) begin
        if (lat_cnt != 0) overlap <= overlap + 1;
        lat_cnt <= LAT;
        lat_ch  <= cnv_chan;
        lat_inj <= cnv_inj;
        if (log_n < LOGN) begin
          log_ch[log_n]  <= int'(cnv_chan);
          log_inj[log_n] <= cnv_inj;
          log_cyc[log_n] <= cyc;
          log_n          <= log_n + 1;
        end
      end else if (lat_cnt > 0) begin
        lat_cnt <= lat_cnt - 1;
      end
      if (cnv_done && lat_inj) inj_done_cyc <= cyc;
    end else begin
      lat_cnt <= 0;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [1:0] m, input int ch);
    cfg_mode  = m;
    cfg_chan  = CH_W'(ch);
    cfg_start = 1'b1;
    tick(1);
    cfg_start = 1'b0;
  endtask

  task automatic pulse_stop();
    cfg_stop = 1'b1;
    tick(1);
    cfg_stop = 1'b0;
  endtask

  task automatic pulse_inj(input int ch);
    inj_chan = CH_W'(ch);
    inj_req  = 1'b1;
    tick(1);
    inj_req  = 1'b0;
  endtask

  task automatic wait_quiet();
    int guard = 0;
    while ((std_run || lat_cnt != 0 || cnv_start) && guard < 5000) begin
      tick(1);
      guard++;
    end
    tick(2);
  endtask

  task automatic wait_log(input int target);
    int guard = 0;
    while (log_n < target && guard < 5000) begin
      tick(1);
      guard++;
    end
  endtask

  task automatic clear_flags();
    std_eoc_clr = 1'b1;
    inj_eoc_clr = 1'b1;
    tick(1);
    std_eoc_clr = 1'b0;
    inj_eoc_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n0, n1, sd;
    bit bad;
    rst_n = 1'b0; cfg_start = 1'b0; cfg_stop = 1'b0; cfg_mode = '0; cfg_chan = '0;
    inj_req = 1'b0; inj_chan = '0; pend_wr = 1'b0; pend_wdata = 1'b0;
    std_eoc_clr = 1'b0; inj_eoc_clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk(!std_run && !inj_pend, "R1 run/pend", int'(std_run), 0);
    chk(!std_eoc && !inj_eoc, "R1 flags", int'(std_eoc), 0);
    chk(!cnv_start, "R1 cnv_start", int'(cnv_start), 0);
    chk(std_data == '0 && inj_data == '0, "R1 data", int'(std_data), 0);

    // R2 single conversion on every channel
    for (int ch = 0; ch < (1 << CH_W); ch++) begin
      n0 = log_n;
      pulse_start(2'd0, ch);
      wait_quiet();
      chk(log_n == n0 + 1, "R2 launch count", log_n - n0, 1);
      chk(log_ch[n0] == ch && !log_inj[n0], "R2 launch chan", log_ch[n0], ch);
      chk(std_data == fval(ch), "R2 std_data", int'(std_data), int'(fval(ch)));
      chk(int'(std_data_chan) == ch, "R2 std_data_chan", int'(std_data_chan), ch);
      chk(std_eoc && !std_run, "R2 eoc/run", int'(std_eoc), 1);
      std_eoc_clr = 1'b1; tick(1); std_eoc_clr = 1'b0;
      chk(!std_eoc, "R13 clear", int'(std_eoc), 0);
    end

    // R4 scan down from every start channel
    for (int b = 0; b < (1 << CH_W); b++) begin
      n0 = log_n;
      pulse_start(2'd2, b);
      wait_quiet();
      chk(log_n == n0 + b + 1, "R4 scan count", log_n - n0, b + 1);
      bad = 1'b0;
      for (int i = 0; i <= b; i++) if (log_ch[n0 + i] != b - i || log_inj[n0 + i]) bad = 1'b1;
      chk(!bad, "R4 scan order", int'(bad), 0);
      chk(std_data_chan == '0 && !std_run, "R4 end chan", int'(std_data_chan), 0);
      clear_flags();
    end

    // R5 repeat scan from 2, stopped after 7 launches
    n0 = log_n;
    pulse_start(2'd3, 2);
    wait_log(n0 + 7);
    pulse_stop();
    n1 = log_n;
    wait_quiet();
    chk(log_n == n1, "R3 stop repeat scan", log_n - n1, 0);
    bad = 1'b0;
    for (int i = 0; i < 7; i++) if (log_ch[n0 + i] != 2 - (i % 3)) bad = 1'b1;
    chk(!bad, "R5 wrap order", int'(bad), 0);
    chk(!std_run, "R5 run cleared", int'(std_run), 0);
    clear_flags();

    // R3 repeat single channel 5
    n0 = log_n;
    pulse_start(2'd1, 5);
    wait_log(n0 + 4);
    pulse_stop();
    n1 = log_n;
    wait_quiet();
    bad = 1'b0;
    for (int i = n0; i < log_n; i++) if (log_ch[i] != 5) bad = 1'b1;
    chk(!bad && n1 >= n0 + 4, "R3 repeat chan", n1 - n0, 4);
    chk(log_n == n1, "R3 no launch after stop", log_n - n1, 0);
    clear_flags();

    // R6/R7 injection on each channel
    for (int ch = 0; ch < (1 << CH_W); ch++) begin
      sd = int'(std_data);
      n0 = log_n;
      pulse_inj(ch);
      chk(inj_pend, "R7 pend set", int'(inj_pend), 1);
      bad = 1'b0;
      for (int g = 0; g < 50 && !inj_eoc; g++) begin
        if (!inj_pend) bad = 1'b1;
        tick(1);
      end
      chk(!bad, "R7 pend held", int'(bad), 0);
      chk(!inj_pend && inj_eoc, "R7 pend cleared at done", int'(inj_pend), 0);
      chk(inj_data == fval(ch), "R6 inj_data", int'(inj_data), int'(fval(ch)));
      chk(int'(std_data) == sd, "R6 std_data kept", int'(std_data), sd);
      chk(log_inj[n0] && log_ch[n0] == ch, "R6 launch kind", int'(log_inj[n0]), 1);
      clear_flags();
    end

    // R8 start during an injected conversion
    n0 = log_n;
    pulse_inj(2);
    tick(1);
    pulse_start(2'd0, 6);
    chk(std_run && log_n == n0 + 1, "R8 std deferred", log_n - n0, 1);
    wait_quiet();
    chk(log_n == n0 + 2 && log_inj[n0] && !log_inj[n0 + 1], "R8 order", log_n - n0, 2);
    chk(log_cyc[n0 + 1] == inj_done_cyc + 1, "R8 launch cycle", log_cyc[n0 + 1], inj_done_cyc + 1);
    chk(inj_data == fval(2) && inj_eoc, "R8 inj not aborted", int'(inj_data), int'(fval(2)));
    chk(std_data == fval(6), "R8 std result", int'(std_data), int'(fval(6)));
    clear_flags();

    // R9 start swept across the injection window
    for (int k = 0; k < 8; k++) begin
      n0 = log_n;
      inj_chan = CH_W'(1);
      inj_req  = 1'b1;
      if (k == 0) begin
        cfg_mode = 2'd0; cfg_chan = CH_W'(3); cfg_start = 1'b1;
      end
      tick(1);
      inj_req = 1'b0;
      cfg_start = 1'b0;
      if (k > 0) begin
        if (k > 1) tick(k - 1);
        pulse_start(2'd0, 3);
      end
      wait_quiet();
      chk(inj_eoc && inj_data == fval(1), "R9 inj result", int'(inj_data), int'(fval(1)));
      chk(std_eoc && std_data == fval(3), "R9 std result", int'(std_data), int'(fval(3)));
      chk(log_n == n0 + 2 && log_inj[n0] && !log_inj[n0 + 1], "R9 order", log_n - n0, 2);
      clear_flags();
      pulse_inj(4);
      wait_quiet();
      chk(inj_eoc && inj_data == fval(4), "R9 later injection", int'(inj_data), int'(fval(4)));
      clear_flags();
    end

    // R10 injection arriving mid-scan
    n0 = log_n;
    pulse_start(2'd2, 3);
    tick(2);
    pulse_inj(7);
    wait_quiet();
    chk(log_n == n0 + 5, "R10 count", log_n - n0, 5);
    chk(log_inj[n0 + 1] && log_ch[n0 + 1] == 7, "R10 inj next", log_ch[n0 + 1], 7);
    chk(log_cyc[n0 + 1] == log_cyc[n0] + LAT + 1, "R10 inj cycle", log_cyc[n0 + 1], log_cyc[n0] + LAT + 1);
    chk(!log_inj[n0 + 2] && log_ch[n0 + 2] == 2 && log_ch[n0 + 4] == 0, "R10 scan resumes", log_ch[n0 + 2], 2);
    clear_flags();

    // R11 software writes to the visible pending bit
    n0 = log_n;
    inj_chan = CH_W'(5); inj_req = 1'b1;
    tick(1);
    inj_req = 1'b0; pend_wr = 1'b1; pend_wdata = 1'b0;
    tick(1);
    pend_wr = 1'b0;
    chk(!inj_pend, "R11 pend written 0", int'(inj_pend), 0);
    wait_quiet();
    chk(inj_eoc && inj_data == fval(5) && log_n == n0 + 1, "R11 injection kept", int'(inj_data), int'(fval(5)));
    clear_flags();
    pend_wr = 1'b1; pend_wdata = 1'b1;
    tick(1);
    pend_wr = 1'b0;
    tick(20);
    chk(log_n == n0 + 1 && !inj_eoc, "R11 no launch from write", log_n - n0, 1);
    chk(inj_pend, "R11 pend written 1", int'(inj_pend), 1);
    pend_wr = 1'b1; pend_wdata = 1'b0;
    tick(1);
    pend_wr = 1'b0;

    // R14 repeated requests while pending
    n0 = log_n;
    inj_chan = CH_W'(6); inj_req = 1'b1;
    tick(1);
    inj_chan = CH_W'(0);
    tick(3);
    inj_req = 1'b0;
    wait_quiet();
    chk(log_n == n0 + 1, "R14 single launch", log_n - n0, 1);
    chk(inj_data == fval(6), "R14 first chan", int'(inj_data), int'(fval(6)));
    clear_flags();

    // R13 clear held through completion
    inj_eoc_clr = 1'b1;
    pulse_inj(2);
    for (int g = 0; g < 50 && inj_pend; g++) tick(1);
    chk(inj_eoc, "R13 set beats clear", int'(inj_eoc), 1);
    tick(1);
    chk(!inj_eoc, "R13 clear next", int'(inj_eoc), 0);
    inj_eoc_clr = 1'b0;

    // R12 one conversion at a time
    chk(overlap == 0, "R12 overlap", overlap, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule